// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by walking a two-level translation table that lives in ordinary memory. A requester presents the virtual address, the access type (read or write, privileged or user) and the physical base of the active first-level table. The walker then reads one descriptor per level over a single-outstanding valid/ready memory port.

A first-level descriptor can be empty, a 1 MB section mapping or a pointer to a second-level table. A second-level descriptor can be empty or a 4 KB page mapping. The walker checks permission at whichever level ends the walk. It then reports the result with a one-cycle done pulse. The result is a physical address, or a fault cause that separates missing mappings from access violations. The walker takes a new request only while it is idle.

Top module: `ptw_walker`

## Requirements
- R1: After synchronous reset, `req_ready` is high, `done` is low and `mem_req_valid` is low.
- R2: The first read goes to address {table_base[31:14], vaddr[31:20], 2'b00}. Bits [13:0] of `table_base` have no effect on the walk.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk with cause 01 (translation fault) and `done_paddr` = 0. No second read is issued.
- R4: A first-level descriptor with bit [1] = 1 is a section. Its permission field sits in bits [11:10]. If the access is allowed, the physical address is {desc[31:20], vaddr[19:0]}.
- R5: A first-level descriptor with bits [1:0] = 01 points to a second-level table. The second read goes to {desc[31:10], vaddr[19:12], 2'b00}.
- R6: A second-level descriptor with bit [1] = 1 is a 4 KB page. Its permission field sits in bits [5:4], and the physical address is {desc[31:12], vaddr[11:0]}. Bit [1] = 0 (codes 00 and 01) gives cause 01.
- R7: The permission field is decoded as follows. 00 denies all access. 01 allows privileged read and write only. 10 adds user read. 11 allows every access. A denied access ends the walk with cause 10 (permission fault), and an allowed one gives cause 00.
- R8: At most one memory read is outstanding. `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready`, and no new read is issued before the response arrives.
- R9: Each accepted request produces exactly one `done` pulse, one cycle wide. While `req_ready` is low, `req_valid` is ignored.
- R10: Whenever the reported cause is nonzero, `done_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_priv | input | 1 | 1 = privileged access, 0 = user |
| table_base | input | 32 | Physical base of the first-level table, 16 KB aligned |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical address of the descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle completion pulse |
| done_cause | output | 2 | 00 ok, 01 translation fault, 10 permission fault |
| done_paddr | output | 32 | Translated physical address (0 on fault) |

## Verification
The walker's state shows up at the ports through two things: the addresses of the descriptor reads it issues and the single result it reports. A wrong first-level index or a wrong table pointer therefore appears on `mem_req_addr` within one cycle of the read request. The bench compares every read address against a queue of expected addresses built from its own model of the tables. A wrong kind decode or a wrong permission decode appears in the cause and address that come with the next done pulse, at most one cycle after the final response. An extra or missing read shows up as a queue mismatch before the walk ends.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_XLATE = 2'b01,
        FLT_PERM  = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        AP_DENY    = 2'b00,
        AP_PRIV    = 2'b01,
        AP_USER_RO = 2'b10,
        AP_ALL     = 2'b11
    } ap_e;

    typedef enum logic [1:0] {
        K_EMPTY,
        K_TABLE,
        K_LEAF
    } kind_e;

    typedef struct packed {
        logic write;
        logic priv;
    } access_t;

    localparam int SECT_AP_LSB = 10;
    localparam int PAGE_AP_LSB = 4;

    function automatic kind_e first_kind(input logic [1:0] code);
        if (code[1])      return K_LEAF;
        else if (code[0]) return K_TABLE;
        return K_EMPTY;
    endfunction

    function automatic kind_e second_kind(input logic [1:0] code);
        return code[1] ? K_LEAF : K_EMPTY;
    endfunction

endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
#(
    parameter int DESC_W = 32,
    parameter int LEVEL  = 1
) (
    input  logic [DESC_W-1:0] desc,
    output kind_e             kind,
    output ap_e               ap
);
    generate
        if (LEVEL == 1) begin : g_first
            assign kind = first_kind(desc[1:0]);
            assign ap   = ap_e'(desc[SECT_AP_LSB +: 2]);
        end else begin : g_second
            assign kind = second_kind(desc[1:0]);
            assign ap   = ap_e'(desc[PAGE_AP_LSB +: 2]);
        end
    endgenerate
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  ap_e     ap,
    input  access_t acc,
    output logic    allowed
);
    always_comb begin
        unique case (ap)
            AP_DENY:    allowed = 1'b0;
            AP_PRIV:    allowed = acc.priv;
            AP_USER_RO: allowed = acc.priv | ~acc.write;
            AP_ALL:     allowed = 1'b1;
            default:    allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptw_addr_form.sv
module ptw_addr_form #(
    parameter int ADDR_W     = 32,
    parameter int L1_IDX_W   = 12,
    parameter int L2_IDX_W   = 8,
    parameter int PAGE_OFF_W = 12
) (
    input  logic [ADDR_W-1:0] new_va,
    input  logic [ADDR_W-1:0] new_base,
    input  logic [ADDR_W-1:0] va,
    input  logic [ADDR_W-1:0] desc,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] second_addr,
    output logic [ADDR_W-1:0] sect_pa,
    output logic [ADDR_W-1:0] page_pa
);
    localparam int SECT_OFF_W  = L2_IDX_W + PAGE_OFF_W;
    localparam int L1_ALIGN_W  = L1_IDX_W + 2;
    localparam int L2_ALIGN_W  = L2_IDX_W + 2;

    assign first_addr  = {new_base[ADDR_W-1:L1_ALIGN_W], new_va[ADDR_W-1 -: L1_IDX_W], 2'b00};
    assign second_addr = {desc[ADDR_W-1:L2_ALIGN_W], va[PAGE_OFF_W +: L2_IDX_W], 2'b00};
    assign sect_pa     = {desc[ADDR_W-1:SECT_OFF_W], va[SECT_OFF_W-1:0]};
    assign page_pa     = {desc[ADDR_W-1:PAGE_OFF_W], va[PAGE_OFF_W-1:0]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int L1_IDX_W   = 12,
    parameter int L2_IDX_W   = 8,
    parameter int PAGE_OFF_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [ADDR_W-1:0] table_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              done,
    output logic [1:0]        done_cause,
    output logic [ADDR_W-1:0] done_paddr
);
    typedef enum logic [2:0] {
        S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT
    } state_e;

    state_e            state;
    logic [ADDR_W-1:0] va_q, addr_q;
    access_t           acc_q;

    logic [ADDR_W-1:0] first_addr, second_addr, sect_pa, page_pa;
    kind_e             kind1, kind2;
    ap_e               ap1, ap2, ap_sel;
    logic              allowed;

    ptw_addr_form #(
        .ADDR_W(ADDR_W), .L1_IDX_W(L1_IDX_W),
        .L2_IDX_W(L2_IDX_W), .PAGE_OFF_W(PAGE_OFF_W)
    ) u_addr (
        .new_va(req_vaddr), .new_base(table_base), .va(va_q), .desc(mem_rsp_data),
        .first_addr(first_addr), .second_addr(second_addr),
        .sect_pa(sect_pa), .page_pa(page_pa)
    );

    ptw_desc_decode #(.DESC_W(ADDR_W), .LEVEL(1)) u_dec1 (
        .desc(mem_rsp_data), .kind(kind1), .ap(ap1)
    );
    ptw_desc_decode #(.DESC_W(ADDR_W), .LEVEL(2)) u_dec2 (
        .desc(mem_rsp_data), .kind(kind2), .ap(ap2)
    );

    assign ap_sel = (state == S_L2_WAIT) ? ap2 : ap1;

    ptw_perm_check u_perm (.ap(ap_sel), .acc(acc_q), .allowed(allowed));

    assign req_ready     = (state == S_IDLE);
    assign mem_req_valid = (state == S_L1_REQ) || (state == S_L2_REQ);
    assign mem_req_addr  = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            va_q       <= '0;
            addr_q     <= '0;
            acc_q      <= '0;
            done       <= 1'b0;
            done_cause <= FLT_NONE;
            done_paddr <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    acc_q  <= '{write: req_write, priv: req_priv};
                    addr_q <= first_addr;
                    state  <= S_L1_REQ;
                end
                S_L1_REQ: if (mem_req_ready) state <= S_L1_WAIT;
                S_L1_WAIT: if (mem_rsp_valid) begin
                    unique case (kind1)
                        K_TABLE: begin
                            addr_q <= second_addr;
                            state  <= S_L2_REQ;
                        end
                        K_LEAF: begin
                            done       <= 1'b1;
                            done_cause <= allowed ? FLT_NONE : FLT_PERM;
                            done_paddr <= allowed ? sect_pa : '0;
                            state      <= S_IDLE;
                        end
                        default: begin
                            done       <= 1'b1;
                            done_cause <= FLT_XLATE;
                            done_paddr <= '0;
                            state      <= S_IDLE;
                        end
                    endcase
                end
                S_L2_REQ: if (mem_req_ready) state <= S_L2_WAIT;
                S_L2_WAIT: if (mem_rsp_valid) begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                    if (kind2 != K_LEAF) begin
                        done_cause <= FLT_XLATE;
                        done_paddr <= '0;
                    end else begin
                        done_cause <= allowed ? FLT_NONE : FLT_PERM;
                        done_paddr <= allowed ? page_pa : '0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !done && !mem_req_valid));

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_one_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_fault_zero_pa_r10: assert property (@(posedge clk) disable iff (rst)
        (done && done_cause != FLT_NONE) |-> (done_paddr == '0));

endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic [31:0] table_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [1:0]  done_cause;
    logic [31:0] done_paddr;

    always #10 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_priv(req_priv),
        .table_base(table_base), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_cause(done_cause), .done_paddr(done_paddr)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int done_seen = 0;
    int walks = 0;

    logic [31:0] mem [int unsigned];
    logic [31:0] exp_addrs [$];

    localparam logic [31:0] BASE = 32'h0010_0000;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic allowed(input logic [1:0] ap, input logic wr, input logic pr);
        case (ap)
            2'b00:   return 1'b0;
            2'b01:   return pr;
            2'b10:   return pr || !wr;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] sect(input logic [11:0] hi, input logic [1:0] ap);
        return {hi, 8'h00, ap, 8'h00, 2'b10};
    endfunction
    function automatic logic [31:0] tbl(input logic [31:0] l2base);
        return {l2base[31:10], 8'h00, 2'b01};
    endfunction
    function automatic logic [31:0] page(input logic [19:0] hi, input logic [1:0] ap);
        return {hi, 6'h00, ap, 2'b00, 2'b10};
    endfunction

    // behavioural reference walk
    task automatic ref_walk(input logic [31:0] va, input logic wr, input logic pr,
                            input logic [31:0] base,
                            output logic [1:0] c, output logic [31:0] pa);
        logic [31:0] a1, d1, a2, d2;
        a1 = {base[31:14], va[31:20], 2'b00};
        exp_addrs.push_back(a1);
        d1 = rd(a1);
        c = 2'b00; pa = 32'h0;
        if (d1[1:0] == 2'b00) c = 2'b01;
        else if (d1[1]) begin
            if (allowed(d1[11:10], wr, pr)) pa = {d1[31:20], va[19:0]};
            else c = 2'b10;
        end else begin
            a2 = {d1[31:10], va[19:12], 2'b00};
            exp_addrs.push_back(a2);
            d2 = rd(a2);
            if (!d2[1]) c = 2'b01;
            else if (allowed(d2[5:4], wr, pr)) pa = {d2[31:12], va[11:0]};
            else c = 2'b10;
        end
    endtask

    // memory responder
    logic        hs_seen = 1'b0;
    logic        resp_pending = 1'b0;
    int          resp_wait = 0;
    logic [31:0] resp_addr = '0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic        prev_done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            mem_rsp_valid = 1'b0;
            if (hs_seen) begin
                resp_pending = 1'b1;
                resp_wait = $urandom % 3;
                hs_seen = 1'b0;
            end
            if (resp_pending) begin
                if (resp_wait == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(resp_addr);
                    resp_pending  = 1'b0;
                end else resp_wait--;
            end
            if (prev_stall)
                chk("R8 request held during stall", {mem_req_valid, mem_req_addr},
                    {1'b1, prev_addr});
            mem_req_ready = ($urandom % 4) != 0;
            if (mem_req_valid && (resp_pending || mem_rsp_valid)) begin
                chk("R8 read while one outstanding", 1, 0);
            end
            if (mem_req_valid && mem_req_ready) begin
                hs_seen   = 1'b1;
                resp_addr = mem_req_addr;
                if (exp_addrs.size() == 0) chk("R8 unexpected read", mem_req_addr, 32'hFFFF_FFFF);
                else chk("R2/R5 descriptor address", mem_req_addr, exp_addrs.pop_front());
            end
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_addr  = mem_req_addr;
            if (done) done_seen++;
            if (done && prev_done) chk("R9 done wider than one cycle", 1, 0);
            prev_done = done;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_walk(input string tag, input logic [31:0] va, input logic wr,
                           input logic pr, input logic [31:0] base, input logic poke);
        logic [1:0]  ec;
        logic [31:0] epa;
        int          n;
        bit          got;
        while (!req_ready) @(negedge clk);
        ref_walk(va, wr, pr, base, ec, epa);
        req_vaddr = va; req_write = wr; req_priv = pr; table_base = base;
        req_valid = 1'b1;
        walks++;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            chk({tag, " R9 busy while walking"}, req_ready, 1'b0);
            req_vaddr = ~va; req_write = ~wr; req_priv = ~pr; table_base = ~base;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            walks += 0;
        end
        got = 0;
        for (n = 0; n < 60 && !got; n++) begin
            if (done) got = 1;
            else @(negedge clk);
        end
        chk({tag, " done arrived"}, got, 1'b1);
        chk({tag, " cause"}, done_cause, ec);
        chk({tag, " paddr"}, done_paddr, epa);
        chk({tag, " R3/R8 all reads issued"}, exp_addrs.size(), 0);
        exp_addrs.delete();
        @(negedge clk);
    endtask

    initial begin
        mem[BASE + 3*4] = sect(12'h805, 2'b11);
        mem[BASE + 5*4] = tbl(32'h0020_0400);
        mem[32'h0020_0400 + 32'h12*4] = page(20'hABCDE, 2'b10);
        mem[32'h0020_0400 + 32'h14*4] = 32'hFFFF_FF01;
        mem[BASE + 6*4] = sect(12'h123, 2'b01);
        mem[BASE + 7*4] = sect(12'h456, 2'b00);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset req_ready", req_ready, 1'b1);
        chk("R1 reset done", done, 1'b0);
        chk("R1 reset mem_req_valid", mem_req_valid, 1'b0);

        do_walk("R4 section full user write", 32'h0030_0ABC, 1, 0, BASE, 0);
        do_walk("R2 base low bits ignored",   32'h0030_0ABC, 0, 1, BASE | 32'h3FFC, 0);
        do_walk("R3 L1 unmapped",             32'h0040_1234, 0, 1, BASE, 0);
        do_walk("R5 R6 page user read",       32'h0051_2345, 0, 0, BASE, 0);
        do_walk("R7 page user write denied",  32'h0051_2345, 1, 0, BASE, 0);
        do_walk("R7 page priv write ok",      32'h0051_2FFF, 1, 1, BASE, 0);
        do_walk("R7 section priv-only user",  32'h0060_0010, 0, 0, BASE, 0);
        do_walk("R7 section priv-only priv",  32'h0060_0010, 1, 1, BASE, 0);
        do_walk("R7 R10 no-access priv",      32'h0070_0000, 0, 1, BASE, 0);
        do_walk("R6 L2 unmapped",             32'h0051_3000, 0, 1, BASE, 0);
        do_walk("R6 L2 code 01 unmapped",     32'h0051_4000, 0, 1, BASE, 0);
        do_walk("R9 request during walk",     32'h0051_2001, 0, 1, BASE, 1);
        do_walk("R4 section offset top",      32'h003F_FFFF, 0, 0, BASE, 0);

        repeat (5) @(negedge clk);
        chk("R9 one done per request", done_seen, walks);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule